// File: doc/BRIEF.md
# Bridge Startup and Bootstrap Refresh Sequencer

This block sits on the controller side of a three-phase half-bridge gate driver. It produces the three high-side and three low-side switch commands and the driver-enable level. After reset it keeps the driver disabled. It then runs a symmetric 50% pattern on all three phases from one shared PWM time base, which charges the pump and bootstrap capacitors. When the supply is flagged as low, this pre-charge lasts a set number of PWM periods. The driver is enabled a fixed lead time before a low-side turn-on edge, so the driver is awake when the low-side switches next close.

Once enabled, the symmetric pattern continues until a run request arrives, so no net motor current flows. In run mode the external commutation commands pass through to the gates. A phase whose high-side is held on continuously gets a short low-side refresh pulse once every refresh period, which tops up its bootstrap capacitor. A fault-clear request drops the enable for a fixed hold time and then restores it, returning to the idle pattern.

Top module: `bridge_startup_seq`

## Requirements
- R1: After reset the state is OFF, `drv_en` is 0 and all six gate commands are 0; `drv_en` stays 0 for as long as the state is OFF or PRECHARGE.
- R2: In PRECHARGE and ENABLED_IDLE all three low-side commands are equal, high for the second half of each PWM period (PWM_PERIOD/2 cycles high, PWM_PERIOD/2 low), and each high-side command is the complement of its low-side command.
- R3: With `low_supply` = 1, PRECHARGE lasts at least PRECHARGE_PERIODS full PWM periods before enable; with `low_supply` = 0, enable follows within the first PWM period of PRECHARGE.
- R4: `drv_en` rises exactly EN_LEAD cycles before a rising edge of the low-side commands.
- R5: ENABLED_IDLE holds, with the symmetric pattern, while `run_req` is 0 and `fault_clr` is 0; `run_req` = 1 moves it to RUN, and `run_req` = 0 in RUN moves it back to ENABLED_IDLE.
- R6: In RUN each phase follows its commands: high-side only gives `gate_hs` = 1, low-side only gives `gate_ls` = 1, and both commanded together turn both gates of that phase off.
- R7: In RUN, a phase with its high-side commanded on alone conducts for REFRESH_PERIOD - REFRESH_WIDTH cycles, then has its high-side off and low-side on for REFRESH_WIDTH cycles, repeating every REFRESH_PERIOD cycles.
- R8: `fault_clr` = 1 in ENABLED_IDLE or RUN drops `drv_en` and all gates to 0 for exactly CLEAR_HOLD cycles, then the state returns to ENABLED_IDLE with `drv_en` = 1; CLEAR_HOLD is chosen at or below a 50 µs window.
- R9: The `state` output encodes OFF = 0, PRECHARGE = 1, ENABLED_IDLE = 2, RUN = 3, FAULT_CLEAR = 4.
- R10: No phase ever has `gate_hs` and `gate_ls` high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_supply | input | 1 | Supply is below the low threshold; lengthens pre-charge |
| run_req | input | 1 | Request to pass commutation commands to the gates |
| fault_clr | input | 1 | Request to clear a latched driver fault |
| cmd_hs | input | 3 | External high-side commands, one bit per phase |
| cmd_ls | input | 3 | External low-side commands, one bit per phase |
| gate_hs | output | 3 | High-side switch commands to the driver |
| gate_ls | output | 3 | Low-side switch commands to the driver |
| drv_en | output | 1 | Driver enable level |
| state | output | 3 | Sequencer state code |

## Verification
Every cycle, the assertions check the following. The low-side commands stay in step during pre-charge and idle. No phase drives both gates. The enable rises out of pre-charge only at the lead point of the shared counter. A fault-clear request drops the enable on the next cycle. A refresh pulse only appears on a phase whose high-side is commanded. Only the bench's scenarios can show the timing over many cycles: the pre-charge length under both supply conditions, the measured lead before the first low-side edge, the half-period widths, the 60/4 refresh rhythm and the exact length of the disable window.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_PRECHARGE = 3'd1,
        ST_IDLE      = 3'd2,
        ST_RUN       = 3'd3,
        ST_CLEAR     = 3'd4
    } seq_state_e;
endpackage

// File: rtl/bsr_timebase.sv
module bsr_timebase #(
    parameter int PWM_PERIOD = 4000,
    localparam int CW = $clog2(PWM_PERIOD),
    localparam int HALF = PWM_PERIOD / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          ls_phase
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_regs_t;

    tb_regs_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == CW'(PWM_PERIOD - 1)) d.cnt = '0;
        else                              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt      = q.cnt;
    assign wrap     = (q.cnt == CW'(PWM_PERIOD - 1));
    assign ls_phase = (q.cnt >= CW'(HALF));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(PWM_PERIOD - 1)) |=> (cnt == '0));
endmodule

// File: rtl/bsr_refresh.sv
module bsr_refresh #(
    parameter int REFRESH_PERIOD = 50000,
    parameter int REFRESH_WIDTH  = 200,
    localparam int TW = $clog2(REFRESH_PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hs_cmd,
    input  logic ls_cmd,
    output logic refresh
);
    typedef struct packed {
        logic [TW-1:0] timer;
    } rf_regs_t;

    rf_regs_t q, d;
    logic     hs_held;

    assign hs_held = en && hs_cmd && !ls_cmd;

    always_comb begin
        d = q;
        if (!hs_held)                                d.timer = '0;
        else if (q.timer == TW'(REFRESH_PERIOD - 1)) d.timer = '0;
        else                                         d.timer = q.timer + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign refresh = hs_held && (q.timer >= TW'(REFRESH_PERIOD - REFRESH_WIDTH));

    // R7
    refresh_needs_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> (en && hs_cmd));
endmodule

// File: rtl/bsr_fsm.sv
module bsr_fsm
    import bsr_pkg::*;
#(
    parameter int PWM_PERIOD       = 4000,
    parameter int EN_LEAD          = 200,
    parameter int PRECHARGE_PERIODS = 8,
    parameter int CLEAR_HOLD       = 1000,
    localparam int CW = $clog2(PWM_PERIOD),
    localparam int HALF = PWM_PERIOD / 2,
    localparam int PW = $clog2(PRECHARGE_PERIODS + 1),
    localparam int HW = $clog2(CLEAR_HOLD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          wrap,
    input  logic          low_supply,
    input  logic          run_req,
    input  logic          fault_clr,
    output seq_state_e    state,
    output logic          drv_en
);
    localparam logic [CW-1:0] EN_AT  = CW'(HALF - EN_LEAD - 1);
    localparam logic [PW-1:0] PC_MAX = PW'(PRECHARGE_PERIODS);
    localparam logic [HW-1:0] HOLD_LAST = HW'(CLEAR_HOLD - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [PW-1:0] pc;
        logic [HW-1:0] clr;
        logic          en;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic      pc_done;

    assign pc_done = (q.pc == PC_MAX) || !low_supply;

    always_comb begin
        d = q;
        case (q.st)
            ST_OFF: begin
                if (wrap) begin
                    d.st = ST_PRECHARGE;
                    d.pc = '0;
                end
            end
            ST_PRECHARGE: begin
                if (wrap && (q.pc != PC_MAX)) d.pc = q.pc + 1'b1;
                if (pc_done && (cnt == EN_AT)) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (fault_clr) begin
                    d.st  = ST_CLEAR;
                    d.clr = '0;
                end else if (run_req) begin
                    d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fault_clr) begin
                    d.st  = ST_CLEAR;
                    d.clr = '0;
                end else if (!run_req) begin
                    d.st = ST_IDLE;
                end
            end
            ST_CLEAR: begin
                if (q.clr == HOLD_LAST) d.st  = ST_IDLE;
                else                    d.clr = q.clr + 1'b1;
            end
            default: d.st = ST_OFF;
        endcase
        d.en = (d.st == ST_IDLE) || (d.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_OFF;
            q.pc  <= '0;
            q.clr <= '0;
            q.en  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state  = q.st;
    assign drv_en = q.en;

    // R4
    enable_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drv_en) && ($past(state) == ST_PRECHARGE)) |-> (cnt == CW'(HALF - EN_LEAD)));

    // R8
    clear_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && ((state == ST_IDLE) || (state == ST_RUN))) |=> !drv_en);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !run_req && !fault_clr) |=> (state == ST_IDLE));

    // R1
    off_stays_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OFF) && !wrap) |=> (!drv_en && (state == ST_OFF)));
endmodule

// File: rtl/bridge_startup_seq.sv
module bridge_startup_seq
    import bsr_pkg::*;
#(
    parameter int PWM_PERIOD        = 4000,
    parameter int EN_LEAD           = 200,
    parameter int PRECHARGE_PERIODS = 8,
    parameter int REFRESH_PERIOD    = 50000,
    parameter int REFRESH_WIDTH     = 200,
    parameter int CLEAR_HOLD        = 1000,
    parameter int PHASES            = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_supply,
    input  logic              run_req,
    input  logic              fault_clr,
    input  logic [PHASES-1:0] cmd_hs,
    input  logic [PHASES-1:0] cmd_ls,
    output logic [PHASES-1:0] gate_hs,
    output logic [PHASES-1:0] gate_ls,
    output logic              drv_en,
    output logic [2:0]        state
);
    localparam int CW = $clog2(PWM_PERIOD);

    logic [CW-1:0]     cnt;
    logic              wrap;
    logic              ls_phase;
    seq_state_e        st;
    logic [PHASES-1:0] refresh;
    logic              run_en;

    bsr_timebase #(.PWM_PERIOD(PWM_PERIOD)) u_tb (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .ls_phase(ls_phase)
    );

    bsr_fsm #(
        .PWM_PERIOD(PWM_PERIOD), .EN_LEAD(EN_LEAD),
        .PRECHARGE_PERIODS(PRECHARGE_PERIODS), .CLEAR_HOLD(CLEAR_HOLD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap),
        .low_supply(low_supply), .run_req(run_req), .fault_clr(fault_clr),
        .state(st), .drv_en(drv_en)
    );

    assign run_en = (st == ST_RUN);

    for (genvar i = 0; i < PHASES; i++) begin : g_phase
        bsr_refresh #(.REFRESH_PERIOD(REFRESH_PERIOD), .REFRESH_WIDTH(REFRESH_WIDTH)) u_rf (
            .clk(clk), .rst_n(rst_n), .en(run_en),
            .hs_cmd(cmd_hs[i]), .ls_cmd(cmd_ls[i]), .refresh(refresh[i])
        );
    end

    always_comb begin
        gate_hs = '0;
        gate_ls = '0;
        for (int i = 0; i < PHASES; i++) begin
            case (st)
                ST_PRECHARGE, ST_IDLE: begin
                    gate_ls[i] = ls_phase;
                    gate_hs[i] = !ls_phase;
                end
                ST_RUN: begin
                    if (refresh[i]) begin
                        gate_ls[i] = 1'b1;
                    end else if (!(cmd_hs[i] && cmd_ls[i])) begin
                        gate_hs[i] = cmd_hs[i];
                        gate_ls[i] = cmd_ls[i];
                    end
                end
                default: ;
            endcase
        end
    end

    assign state = st;

    // R10
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hs & gate_ls) == '0));

    // R2
    pattern_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PRECHARGE) || (st == ST_IDLE)) |-> ((gate_ls == '0) || (gate_ls == '1)));
endmodule

// File: tb/sim_bridge_startup_seq.sv
module sim_bridge_startup_seq;
    localparam int P    = 16;
    localparam int LEAD = 2;
    localparam int PCN  = 2;
    localparam int RP   = 64;
    localparam int RW   = 4;
    localparam int HOLD = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic low_supply = 1, run_req = 0, fault_clr = 0;
    logic [2:0] cmd_hs = '0, cmd_ls = '0;
    logic [2:0] gate_hs, gate_ls, state;
    logic drv_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bridge_startup_seq #(
        .PWM_PERIOD(P), .EN_LEAD(LEAD), .PRECHARGE_PERIODS(PCN),
        .REFRESH_PERIOD(RP), .REFRESH_WIDTH(RW), .CLEAR_HOLD(HOLD), .PHASES(3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .run_req(run_req),
        .fault_clr(fault_clr), .cmd_hs(cmd_hs), .cmd_ls(cmd_ls),
        .gate_hs(gate_hs), .gate_ls(gate_ls), .drv_en(drv_en), .state(state)
    );

    // {cmd_hs, cmd_ls, expected gate_hs, expected gate_ls}
    localparam logic [11:0] VEC [8] = '{
        {3'b000, 3'b000, 3'b000, 3'b000},
        {3'b001, 3'b000, 3'b001, 3'b000},
        {3'b000, 3'b010, 3'b000, 3'b010},
        {3'b100, 3'b011, 3'b100, 3'b011},
        {3'b011, 3'b001, 3'b010, 3'b000},
        {3'b111, 3'b111, 3'b000, 3'b000},
        {3'b010, 3'b101, 3'b010, 3'b101},
        {3'b101, 3'b110, 3'b001, 3'b010}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) step();
        rst_n = 1;
    endtask

    // R10 monitor on every sample
    always @(negedge clk) begin
        if (rst_n && ((gate_hs & gate_ls) != 3'b000)) begin
            fails++;
            $display("FAIL R10 actual=%0d expected=%0d", gate_hs & gate_ls, 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int bad;
        do_reset();
        #1;
        // R1, R9: reset state
        chk(state == 3'd0, "R9 reset state OFF", state, 0);
        chk(!drv_en && gate_hs == 0 && gate_ls == 0, "R1 reset outputs", {drv_en, gate_hs, gate_ls}, 0);

        // R1/R3: pre-charge with low supply
        n = 0;
        while (state != 3'd1 && n < 1000) begin step(); n++; end
        n = 0; bad = 0;
        while (!drv_en && n < 1000) begin
            if (state != 3'd1 && state != 3'd0) bad++;
            if (gate_ls != 3'b000 && gate_ls != 3'b111) bad++;
            step(); n++;
        end
        chk(n >= PCN * P, "R3 low-supply pre-charge length", n, PCN * P);
        chk(bad == 0, "R2 synchronous pre-charge pattern", bad, 0);
        chk(state == 3'd2, "R9 enabled idle code", state, 2);

        // R4: lead before low-side rise
        n = 0;
        while (gate_ls[0] == 1'b0 && n < 100) begin step(); n++; end
        chk(n == LEAD, "R4 enable lead", n, LEAD);

        // R2: half-period widths
        n = 0;
        while (gate_ls[0] == 1'b1 && n < 100) begin
            if (gate_hs != ~gate_ls) bad++;
            step(); n++;
        end
        chk(n == P / 2, "R2 low-side high width", n, P / 2);
        n = 0;
        while (gate_ls[0] == 1'b0 && n < 100) begin step(); n++; end
        chk(n == P / 2, "R2 low-side low width", n, P / 2);
        chk(bad == 0, "R2 high-side complement", bad, 0);

        // R5: idle holds without request
        repeat (20) step();
        chk(state == 3'd2 && drv_en, "R5 idle holds", state, 2);
        run_req = 1;
        step();
        chk(state == 3'd3, "R5 run entry", state, 3);

        // R6: command table
        foreach (VEC[k]) begin
            cmd_hs = '0; cmd_ls = '0;
            step();
            cmd_hs = VEC[k][11:9];
            cmd_ls = VEC[k][8:6];
            #1;
            chk(gate_hs == VEC[k][5:3], "R6 high-side pass", gate_hs, VEC[k][5:3]);
            chk(gate_ls == VEC[k][2:0], "R6 low-side pass", gate_ls, VEC[k][2:0]);
        end

        // R7: refresh on phase 1
        cmd_hs = '0; cmd_ls = '0;
        step();
        cmd_hs = 3'b010;
        #1;
        n = 0;
        while (gate_hs[1] && n < 1000) begin step(); n++; end
        chk(n == RP - RW, "R7 conduction before refresh", n, RP - RW);
        n = 0; bad = 0;
        while (!gate_hs[1] && n < 1000) begin
            if (!gate_ls[1]) bad++;
            step(); n++;
        end
        chk(n == RW, "R7 refresh width", n, RW);
        chk(bad == 0, "R7 low-side on during refresh", bad, 0);
        n = 0;
        while (gate_hs[1] && n < 1000) begin step(); n++; end
        chk(n == RP - RW, "R7 refresh period repeat", n, RP - RW);

        // R8: fault clear
        cmd_hs = '0;
        step();
        fault_clr = 1;
        step();
        fault_clr = 0;
        run_req = 0;
        chk(state == 3'd4, "R9 fault-clear code", state, 4);
        n = 0; bad = 0;
        while (!drv_en && n < 1000) begin
            if (gate_hs != 0 || gate_ls != 0) bad++;
            step(); n++;
        end
        chk(n == HOLD, "R8 disable hold length", n, HOLD);
        chk(bad == 0, "R8 gates off during clear", bad, 0);
        chk(state == 3'd2, "R8 return to idle", state, 2);
        repeat (5) step();
        chk(state == 3'd2, "R5 idle after run drop", state, 2);

        // R3: normal supply enables within first period
        low_supply = 0;
        do_reset();
        n = 0;
        while (state != 3'd1 && n < 1000) begin step(); n++; end
        n = 0;
        while (!drv_en && n < 1000) begin step(); n++; end
        chk(n < P, "R3 normal-supply pre-charge length", n, P);
        n = 0;
        while (gate_ls[0] == 1'b0 && n < 100) begin step(); n++; end
        chk(n == LEAD, "R4 enable lead normal supply", n, LEAD);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule